// File: doc/BRIEF.md
# Programmable Hysteretic Field Switch

This block turns a stream of signed magnetic-field samples, one per clock, into the on/off decision of an open-drain switch output. An 8-bit magnitude code and a sign-select bit place the operate threshold anywhere in a span that crosses zero. The release threshold sits a fixed hysteresis below the operate threshold, measured in the direction of the selected field sign. An inversion bit swaps the sense of the output. Configuration arrives as static inputs from a programming block outside this one.

After reset, a power-on counter holds the decision in its off state for a set number of cycles, so the pin rests at its defined power-on level. When the pull-down engages, it does so as a staircase of drive-strength steps chosen by a 2-bit slope selector. This keeps the falling edge of the pin slow. When the pull-down releases, it drops to zero steps at once.

Top module: `switchpoint_cmp`

## Requirements
- R1: With `north_sel`=0, the operate threshold is 4·`mag_code` − 20 (units of 1 G, so code 0 gives −20 and code 255 gives 1000). The switch operates on the first ready cycle in which `field` is strictly greater than that threshold.
- R2: With `north_sel`=1, the mapping is mirrored. The switch operates when `field` < 20 − 4·`mag_code`, and it releases when `field` > 20 − 4·`mag_code` + 15.
- R3: With `north_sel`=0, the switch releases when `field` is strictly below the operate threshold minus 15.
- R4: A field that lies between the release and operate thresholds, including either threshold value itself, leaves the switch state unchanged.
- R5: `sink_on` equals the switch state XOR `out_inv`. It follows `out_inv` in the same cycle.
- R6: From reset until 32 clock edges have passed after reset release, the switch state stays off. During that time `sink_on` equals `out_inv`, whatever the field is.
- R7: While `sink_on` is 1, `sink_steps` rises by exactly one per clock from 0 up to a cap of 1, 4, 6 or 8 for `fall_sel` = 0, 1, 2 or 3. It then holds at the cap.
- R8: In the clock after `sink_on` is seen at 0, `sink_steps` is 0. The release of the pull-down takes no ramp.
- R9: If `fall_sel` is lowered while the staircase is above the new cap, `sink_steps` is clamped to the new cap on the next clock.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| field | input | 12 | Signed field sample, 1 G per LSB |
| mag_code | input | 8 | Threshold magnitude code |
| north_sel | input | 1 | 1 selects the mirrored (north) threshold mapping |
| out_inv | input | 1 | Inverts the output sense |
| fall_sel | input | 2 | Selects the pull-down staircase length |
| sink_on | output | 1 | Pull-down requested (pin low) |
| sink_steps | output | 4 | Pull-down drive-strength steps engaged |

## Verification
The hardest case to reach is a configuration change that lands while the staircase is still climbing. When `fall_sel` drops below the current step count in the middle of a ramp, the clamp path is taken instead of the increment path. The stimulus reaches it by driving a strong field with the longest setting and waiting a few cycles. It then lowers the selector mid-ramp, and later flips `out_inv` during a ramp to cut the ramp short. A behavioural reference model in the bench tracks threshold, hysteresis, power-on window and staircase, and it is compared with the ports on every clock. The compared cases include field sweeps across several codes in both sign settings.

// File: rtl/switchpoint_cmp.sv
module switchpoint_cmp #(
  parameter int FW    = 12,
  parameter int CW    = 8,
  parameter int STEP  = 4,
  parameter int BASE  = 20,
  parameter int HYST  = 15,
  parameter int PON   = 32,
  parameter int CAP0  = 1,
  parameter int CAP1  = 4,
  parameter int CAP2  = 6,
  parameter int CAP3  = 8,
  parameter int SW    = 4
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [FW-1:0] field,
  input  logic [CW-1:0] mag_code,
  input  logic          north_sel,
  input  logic          out_inv,
  input  logic [1:0]    fall_sel,
  output logic          sink_on,
  output logic [SW-1:0] sink_steps
);
  localparam int EW   = FW + 4;
  localparam int PONW = $clog2(PON + 1);

  logic signed [EW-1:0] fld_x, mag, thr, rel;
  logic [PONW-1:0] pon_cnt;
  logic            ready;
  logic            operated;
  logic [SW-1:0]   cap;

  assign fld_x = EW'($signed(field));
  assign mag   = north_sel ? -fld_x : fld_x;
  assign thr   = $signed(EW'(STEP * int'(mag_code))) - $signed(EW'(BASE));
  assign rel   = thr - $signed(EW'(HYST));
  assign ready = (pon_cnt == PONW'(PON));

  always_comb begin
    case (fall_sel)
      2'd0:    cap = SW'(CAP0);
      2'd1:    cap = SW'(CAP1);
      2'd2:    cap = SW'(CAP2);
      default: cap = SW'(CAP3);
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      pon_cnt <= '0;
    else if (!ready) pon_cnt <= pon_cnt + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) operated <= 1'b0;
    else if (ready) begin
      if (mag > thr)      operated <= 1'b1;
      else if (mag < rel) operated <= 1'b0;
    end
  end

  assign sink_on = operated ^ out_inv;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                 sink_steps <= '0;
    else if (!sink_on)          sink_steps <= '0;
    else if (sink_steps > cap)  sink_steps <= cap;
    else if (sink_steps < cap)  sink_steps <= sink_steps + 1'b1;
  end
endmodule

// File: rtl/switchpoint_cmp_chk.sv
module switchpoint_cmp_chk #(
  parameter int FW   = 12,
  parameter int CW   = 8,
  parameter int PON  = 32,
  parameter int SW   = 4
) (
  input logic          clk,
  input logic          rst_n,
  input logic [FW-1:0] field,
  input logic [CW-1:0] mag_code,
  input logic          north_sel,
  input logic          out_inv,
  input logic [1:0]    fall_sel,
  input logic          sink_on,
  input logic [SW-1:0] sink_steps
);
  int cnt;
  int m, t;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       cnt <= 0;
    else if (cnt < PON) cnt <= cnt + 1;
  end
  always_comb begin
    m = north_sel ? -int'($signed(field)) : int'($signed(field));
    t = 4 * int'(mag_code) - 20;
  end

  function automatic int cap_of(input logic [1:0] s);
    case (s)
      2'd0: cap_of = 1;
      2'd1: cap_of = 4;
      2'd2: cap_of = 6;
      default: cap_of = 8;
    endcase
  endfunction

  AST_PON_STATE: assert property (@(posedge clk) disable iff (!rst_n)
    (cnt < PON) |-> (sink_on == out_inv)); // R6
  AST_OPERATE: assert property (@(posedge clk) disable iff (!rst_n)
    (cnt == PON && m > t) |=> (sink_on ^ out_inv)); // R1
  AST_RELEASE: assert property (@(posedge clk) disable iff (!rst_n)
    (cnt == PON && m < t - 15) |=> !(sink_on ^ out_inv)); // R3
  AST_RISE_FAST: assert property (@(posedge clk) disable iff (!rst_n)
    !sink_on |=> (sink_steps == 0)); // R8
  AST_RAMP_ONE: assert property (@(posedge clk) disable iff (!rst_n)
    (sink_steps > $past(sink_steps)) |-> (sink_steps == $past(sink_steps) + 1'b1)); // R7
  AST_STEP_CAP: assert property (@(posedge clk) disable iff (!rst_n)
    (int'(sink_steps) <= cap_of($past(fall_sel)))); // R9
endmodule

bind switchpoint_cmp switchpoint_cmp_chk #(.FW(FW), .CW(CW), .PON(PON), .SW(SW)) u_chk (
  .clk(clk), .rst_n(rst_n), .field(field), .mag_code(mag_code),
  .north_sel(north_sel), .out_inv(out_inv), .fall_sel(fall_sel),
  .sink_on(sink_on), .sink_steps(sink_steps)
);

// File: tb/switchpoint_cmp_test.sv
module switchpoint_cmp_test;
  localparam int CLK_P = 10;
  localparam int PON   = 32;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [11:0] field = '0;
  logic [7:0]  mag_code = '0;
  logic        north_sel = 1'b0;
  logic        out_inv = 1'b0;
  logic [1:0]  fall_sel = '0;
  logic        sink_on;
  logic [3:0]  sink_steps;

  int    n_tests = 0, n_fail = 0;
  string cur_req = "R6";
  bit    done = 0;

  int m_cnt, m_steps;
  bit m_op;

  switchpoint_cmp uut (
    .clk(clk), .rst_n(rst_n), .field(field), .mag_code(mag_code),
    .north_sel(north_sel), .out_inv(out_inv), .fall_sel(fall_sel),
    .sink_on(sink_on), .sink_steps(sink_steps)
  );

  always #(CLK_P/2) clk = ~clk;

  function automatic int cap_of(input int s);
    return (s == 0) ? 1 : (s == 1) ? 4 : (s == 2) ? 6 : 8;
  endfunction

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_cnt = 0; m_op = 0; m_steps = 0;
    end else begin
      int f, thr, c;
      bit on_now;
      on_now = m_op ^ out_inv;
      f = $signed(field);
      if (north_sel) f = -f;
      thr = 4 * int'(mag_code) - 20;
      c = cap_of(int'(fall_sel));
      if (!on_now) m_steps = 0;
      else if (m_steps > c) m_steps = c;
      else if (m_steps < c) m_steps = m_steps + 1;
      if (m_cnt == PON) begin
        if (f > thr) m_op = 1;
        else if (f < thr - 15) m_op = 0;
      end else m_cnt = m_cnt + 1;
    end
  end

  always @(negedge clk) begin
    if (!done) begin
      bit exp_on;
      exp_on = m_op ^ out_inv;
      n_tests++;
      if (sink_on !== exp_on || int'(sink_steps) != m_steps) begin
        n_fail++;
        $display("FAIL %s: sink_on=%0b steps=%0d expected sink_on=%0b steps=%0d",
                 cur_req, sink_on, sink_steps, exp_on, m_steps);
      end
    end
  end

  task automatic tick(input int n);
    repeat (n) begin @(posedge clk); #(CLK_P/4); end
  endtask

  task automatic put(input int f, input int n);
    field = 12'(f); tick(n);
  endtask

  initial begin
    // R6: reset state and power-on hold with a strong field
    cur_req = "R6";
    field = 12'(500); mag_code = 8'd10; fall_sel = 2'd3;
    tick(3);
    rst_n = 1'b1;
    tick(PON + 4);

    // R1 / R3 / R4: south thresholds, code 10 -> operate 20, release 5
    cur_req = "R1";
    put(-100, 4); put(20, 3); put(21, 12);
    cur_req = "R4";
    put(5, 4); put(12, 4);
    cur_req = "R3";
    put(4, 4); put(19, 4);
    cur_req = "R1";
    mag_code = 8'd255; put(1000, 3); put(1001, 10);
    cur_req = "R3";
    put(984, 3); put(985, 3); put(0, 4);

    // R2: north mirror, code 10 -> operate below -20, release above -5
    cur_req = "R2";
    north_sel = 1'b1; mag_code = 8'd10;
    put(0, 3); put(-20, 3); put(-21, 10);
    put(-5, 3); put(-4, 4);
    mag_code = 8'd0; put(19, 3); put(21, 6); put(36, 4);

    // R5: inversion
    cur_req = "R5";
    north_sel = 1'b0; mag_code = 8'd50; put(0, 3);
    out_inv = 1'b1; tick(10);
    put(300, 10);
    out_inv = 1'b0; tick(5);

    // R7 / R8: staircases per setting
    for (int s = 0; s < 4; s++) begin
      cur_req = "R7";
      fall_sel = 2'(s); put(-200, 3); put(400, 12);
      cur_req = "R8";
      put(-200, 4);
    end

    // R9: lower the cap mid ramp, cut a ramp with out_inv
    cur_req = "R9";
    fall_sel = 2'd3; put(400, 6);
    fall_sel = 2'd0; tick(4);
    fall_sel = 2'd2; tick(8);
    cur_req = "R8";
    put(-200, 2); put(400, 3);
    out_inv = 1'b1; tick(3); out_inv = 1'b0; tick(4);

    // R4: sweeps across several codes both directions
    cur_req = "R4";
    for (int k = 0; k < 6; k++) begin
      mag_code = 8'(k * 47); north_sel = k[0];
      for (int f = -1100; f <= 1100; f += 7) put(f, 1);
      for (int f = 1100; f >= -1100; f -= 7) put(f, 1);
    end

    // R6: power-on with inverted sense
    cur_req = "R6";
    out_inv = 1'b1; north_sel = 1'b0; mag_code = 8'd0; field = 12'(700);
    rst_n = 1'b0; tick(2);
    rst_n = 1'b1; tick(PON + 6);

    done = 1;
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    #(CLK_P * 150000);
    if (!done) begin
      done = 1;
      n_tests++; n_fail++;
      $display("FAIL watchdog: run did not finish, expected completion");
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end
endmodule